// File: doc/BRIEF.md
# Register Rename Table with Reorder-Buffer Tags

This block sits beside the architectural register file of an out-of-order core that retires through a reorder buffer. For every instruction that issues, it resolves each source register. A source comes back ready, carrying the register-file value, or pending, carrying the reorder-buffer tag of the instruction that will produce it. The same issue then points the destination register at the tag just allocated for that instruction.

When an instruction retires, its result is written into the register file. The rename entry for that register is released only if it still names the retiring tag, so a younger rename of the same register is kept. A flush caused by a misprediction or an exception releases every rename entry in one cycle. After a flush, all sources resolve from the register file, which holds only retired state.

The reorder-buffer storage and the reservation stations are outside this block.

Top module: `rename_table`

## Requirements
- R1: After reset every register is unmapped and holds zero, so every source reads ready with value 0.
- R2: A source register with no mapping reads ready=1, value equal to the register-file contents, and tag 0.
- R3: A source register that is mapped, and not bypassed by R8, reads ready=0, tag equal to the mapped tag, and value 0.
- R4: When iss_valid=1 and iss_dst_en=1, the destination register maps to iss_tag from the next cycle on. Sources looked up in that same cycle still see the previous mapping.
- R5: When cmt_valid=1, cmt_value is written into register cmt_dst. The write happens whether or not the register is mapped, and also during a flush.
- R6: A commit releases the mapping of cmt_dst only if that mapping is valid and holds cmt_tag. A mapping holding any other tag stays unchanged.
- R7: If an issue renames the same register that a commit releases in the same cycle, the new mapping from the issue is kept.
- R8: If cmt_valid=1 and a source register is mapped to cmt_tag with cmt_dst equal to that register, the source reads ready=1 with value cmt_value in that same cycle.
- R9: flush=1 releases every mapping at the next edge. It suppresses any rename requested in that cycle.
- R10: With iss_valid=0 or iss_dst_en=0, no mapping changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Release all mappings (misprediction or exception) |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_en | input | 1 | The issuing instruction writes a destination register |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 3 | Reorder-buffer tag allocated to the issuing instruction |
| src0_idx | input | 4 | First source register index |
| src1_idx | input | 4 | Second source register index |
| src0_ready | output | 1 | First source value is available |
| src0_tag | output | 3 | Producer tag of first source when not ready, else 0 |
| src0_value | output | 32 | First source value when ready, else 0 |
| src1_ready | output | 1 | Second source value is available |
| src1_tag | output | 3 | Producer tag of second source when not ready, else 0 |
| src1_value | output | 32 | Second source value when ready, else 0 |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_dst | input | 4 | Register written by the retiring instruction |
| cmt_tag | input | 3 | Tag of the retiring instruction |
| cmt_value | input | 32 | Result of the retiring instruction |

## Verification
The bench targets a stale commit that arrives after the same register has been renamed again. A design that releases the mapping unconditionally would wrongly show the older value as ready. It also drives an issue and a commit to one register in the same cycle, where letting the release win would lose the newest producer. Same-cycle bypass is covered too: missing it leaves a source waiting on a tag that has already retired. Flushes are sent together with renames and commits, to catch a design that keeps the rename or drops the retiring write.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int NUM_REGS = 16;
  parameter int DATA_W   = 32;
  parameter int TAG_W    = 3;
  localparam int IDX_W   = $clog2(NUM_REGS);

  typedef logic [IDX_W-1:0]  ridx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] word_t;

  // a mapping still belongs to the retiring instruction
  function automatic logic owner_match(logic held_v, tag_t held_t, tag_t ctag);
    return held_v && (held_t == ctag);
  endfunction

  // an enabled request addresses a given register
  function automatic logic idx_hit(logic en, ridx_t a, ridx_t b);
    return en && (a == b);
  endfunction
endpackage

// File: rtl/rename_map.sv
module rename_map
  import rat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                ren_fire,
  input  ridx_t               ren_idx,
  input  tag_t                ren_tag,
  input  logic                cmt_valid,
  input  ridx_t               cmt_idx,
  input  tag_t                cmt_tag,
  output logic [NUM_REGS-1:0] map_valid,
  output tag_t                map_tag [NUM_REGS],
  output logic                clr_fire
);
  logic [NUM_REGS-1:0] clr_hit;
  logic [NUM_REGS-1:0] ren_hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    assign clr_hit[i] = idx_hit(cmt_valid, cmt_idx, ridx_t'(i)) &&
                        owner_match(map_valid[i], map_tag[i], cmt_tag);
    assign ren_hit[i] = idx_hit(ren_fire, ren_idx, ridx_t'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_valid[i] <= 1'b0;
        map_tag[i]   <= '0;
      end else if (flush) begin
        map_valid[i] <= 1'b0;
      end else if (ren_hit[i]) begin
        map_valid[i] <= 1'b1;
        map_tag[i]   <= ren_tag;
      end else if (clr_hit[i]) begin
        map_valid[i] <= 1'b0;
      end
    end
  end

  assign clr_fire = |clr_hit;

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (map_valid == '0));

  // R4
  rename_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !flush) |=>
      (map_valid[$past(ren_idx)] && map_tag[$past(ren_idx)] == $past(ren_tag)));

  // R6
  owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !flush && map_valid[cmt_idx] && map_tag[cmt_idx] == cmt_tag &&
     !(ren_fire && ren_idx == cmt_idx)) |=> !map_valid[$past(cmt_idx)]);

  // R6
  stale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !flush && map_valid[cmt_idx] && map_tag[cmt_idx] != cmt_tag &&
     !(ren_fire && ren_idx == cmt_idx)) |=>
      (map_valid[$past(cmt_idx)] && map_tag[$past(cmt_idx)] == $past(map_tag[cmt_idx])));
endmodule

// File: rtl/arch_regfile.sv
module arch_regfile
  import rat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ridx_t wr_idx,
  input  word_t wr_data,
  output word_t rf_q [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        rf_q[i] <= '0;
      else if (idx_hit(wr_en, wr_idx, ridx_t'(i)))
        rf_q[i] <= wr_data;
    end
  end

  // R5
  commit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rf_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/src_lookup.sv
module src_lookup
  import rat_pkg::*;
(
  input  ridx_t               src_idx,
  input  logic [NUM_REGS-1:0] map_valid,
  input  tag_t                map_tag [NUM_REGS],
  input  word_t               rf_q [NUM_REGS],
  input  logic                cmt_valid,
  input  ridx_t               cmt_idx,
  input  tag_t                cmt_tag,
  input  word_t               cmt_data,
  output logic                ready,
  output tag_t                tag,
  output word_t               value,
  output logic                byp_hit
);
  logic mapped;

  assign mapped  = map_valid[src_idx];
  assign byp_hit = mapped && idx_hit(cmt_valid, cmt_idx, src_idx) &&
                   owner_match(mapped, map_tag[src_idx], cmt_tag);

  always_comb begin
    if (!mapped) begin
      ready = 1'b1;
      tag   = '0;
      value = rf_q[src_idx];
    end else if (byp_hit) begin
      ready = 1'b1;
      tag   = '0;
      value = cmt_data;
    end else begin
      ready = 1'b0;
      tag   = map_tag[src_idx];
      value = '0;
    end
  end
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic              iss_dst_en,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  src0_idx,
  input  logic [IDX_W-1:0]  src1_idx,
  output logic              src0_ready,
  output logic [TAG_W-1:0]  src0_tag,
  output logic [DATA_W-1:0] src0_value,
  output logic              src1_ready,
  output logic [TAG_W-1:0]  src1_tag,
  output logic [DATA_W-1:0] src1_value,
  input  logic              cmt_valid,
  input  logic [IDX_W-1:0]  cmt_dst,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic [DATA_W-1:0] cmt_value
);
  logic [NUM_REGS-1:0] map_valid;
  tag_t                map_tag [NUM_REGS];
  word_t               rf_q [NUM_REGS];
  logic                ren_fire;
  logic                clr_fire;
  logic                byp0;
  logic                byp1;

  assign ren_fire = iss_valid && iss_dst_en;

  rename_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ren_fire  (ren_fire),
    .ren_idx   (iss_dst),
    .ren_tag   (iss_tag),
    .cmt_valid (cmt_valid),
    .cmt_idx   (cmt_dst),
    .cmt_tag   (cmt_tag),
    .map_valid (map_valid),
    .map_tag   (map_tag),
    .clr_fire  (clr_fire)
  );

  arch_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmt_valid),
    .wr_idx  (cmt_dst),
    .wr_data (cmt_value),
    .rf_q    (rf_q)
  );

  src_lookup u_src0 (
    .src_idx   (src0_idx),
    .map_valid (map_valid),
    .map_tag   (map_tag),
    .rf_q      (rf_q),
    .cmt_valid (cmt_valid),
    .cmt_idx   (cmt_dst),
    .cmt_tag   (cmt_tag),
    .cmt_data  (cmt_value),
    .ready     (src0_ready),
    .tag       (src0_tag),
    .value     (src0_value),
    .byp_hit   (byp0)
  );

  src_lookup u_src1 (
    .src_idx   (src1_idx),
    .map_valid (map_valid),
    .map_tag   (map_tag),
    .rf_q      (rf_q),
    .cmt_valid (cmt_valid),
    .cmt_idx   (cmt_dst),
    .cmt_tag   (cmt_tag),
    .cmt_data  (cmt_value),
    .ready     (src1_ready),
    .tag       (src1_tag),
    .value     (src1_value),
    .byp_hit   (byp1)
  );

  // R8
  bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && clr_fire && src0_idx == cmt_dst && map_valid[cmt_dst]) |->
      (src0_ready && src0_value == cmt_value));

  // R3
  pending_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid[src1_idx] && !byp1) |-> (!src1_ready && src1_tag == map_tag[src1_idx]));

  // R7
  issue_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !flush && clr_fire && iss_dst == cmt_dst) |=> map_valid[$past(iss_dst)]);
endmodule

// File: tb/rename_table_tb.sv
module rename_table_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_dst_en = 1'b0;
  logic [3:0]  iss_dst = '0;
  logic [2:0]  iss_tag = '0;
  logic [3:0]  src0_idx = '0;
  logic [3:0]  src1_idx = '0;
  logic        src0_ready, src1_ready;
  logic [2:0]  src0_tag, src1_tag;
  logic [31:0] src0_value, src1_value;
  logic        cmt_valid = 1'b0;
  logic [3:0]  cmt_dst = '0;
  logic [2:0]  cmt_tag = '0;
  logic [31:0] cmt_value = '0;

  always #2.5 clk = ~clk;

  rename_table u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src0_idx(src0_idx), .src1_idx(src1_idx),
    .src0_ready(src0_ready), .src0_tag(src0_tag), .src0_value(src0_value),
    .src1_ready(src1_ready), .src1_tag(src1_tag), .src1_value(src1_value),
    .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_tag(cmt_tag), .cmt_value(cmt_value)
  );

  // behavioural model
  bit          m_busy [16];
  int          m_owner [16];
  longint      m_file [16];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  string       focus = "";

  task automatic expect_src(int s, int r, logic rdy, logic [2:0] tg, logic [31:0] v);
    logic  e_rdy;
    int    e_tag;
    longint e_val;
    string req;
    if (!m_busy[r]) begin
      e_rdy = 1; e_tag = 0; e_val = m_file[r]; req = "R2";
    end else if (cmt_valid && int'(cmt_dst) == r && int'(cmt_tag) == m_owner[r]) begin
      e_rdy = 1; e_tag = 0; e_val = cmt_value; req = "R8";
    end else begin
      e_rdy = 0; e_tag = m_owner[r]; e_val = 0; req = "R3";
    end
    checks++;
    if (rdy !== e_rdy || int'(tg) != e_tag || longint'(v) != e_val) begin
      errors++;
      $display("FAIL %s [%s] src%0d reg %0d: got rdy=%0b tag=%0d val=%h, expected rdy=%0b tag=%0d val=%h",
               req, focus, s, r, rdy, tg, v, e_rdy, e_tag, e_val[31:0]);
    end
  endtask

  task automatic step();
    #1;
    expect_src(0, int'(src0_idx), src0_ready, src0_tag, src0_value);
    expect_src(1, int'(src1_idx), src1_ready, src1_tag, src1_value);
    @(posedge clk);
    if (cmt_valid) begin
      m_file[cmt_dst] = cmt_value;
      if (!flush && m_busy[cmt_dst] && m_owner[cmt_dst] == int'(cmt_tag))
        m_busy[cmt_dst] = 0;
    end
    if (flush) begin
      for (int i = 0; i < 16; i++) m_busy[i] = 0;
    end else if (iss_valid && iss_dst_en) begin
      m_busy[iss_dst] = 1;
      m_owner[iss_dst] = int'(iss_tag);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; iss_valid = 0; iss_dst_en = 0; cmt_valid = 0;
  endtask

  task automatic issue(int d, int t);
    iss_valid = 1; iss_dst_en = 1; iss_dst = 4'(d); iss_tag = 3'(t);
  endtask

  task automatic retire(int d, int t, logic [31:0] v);
    cmt_valid = 1; cmt_dst = 4'(d); cmt_tag = 3'(t); cmt_value = v;
  endtask

  task automatic look(int a, int b);
    src0_idx = 4'(a); src1_idx = 4'(b);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_busy[i] = 0; m_owner[i] = 0; m_file[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state across all registers
    focus = "R1";
    for (int r = 0; r < 16; r++) begin
      idle(); look(r, 15 - r);
      #1;
      checks++;
      if (src0_ready !== 1'b1 || src0_value !== 32'd0) begin
        errors++;
        $display("FAIL R1 reg %0d: got rdy=%0b val=%h, expected rdy=1 val=0", r, src0_ready, src0_value);
      end
      step();
    end

    // R5: commit into an unmapped register, then read it back (R2)
    focus = "R5";
    idle(); retire(3, 0, 32'hA5A5_0001); look(3, 4); step();
    idle(); look(3, 3); step();

    // R4: rename is not seen by same-cycle sources, seen next cycle
    focus = "R4";
    idle(); issue(3, 1); look(3, 0); step();
    idle(); look(3, 3); step();

    // R6: stale commit leaves the younger mapping
    focus = "R6";
    idle(); issue(3, 2); look(3, 1); step();
    idle(); retire(3, 1, 32'h0000_BBBB); look(3, 3); step();
    idle(); look(3, 2); step();
    // R8: owning commit bypasses to the source, then the mapping is gone
    focus = "R8";
    idle(); retire(3, 2, 32'h0000_CCCC); look(3, 3); step();
    focus = "R6";
    idle(); look(3, 3); step();

    // R7: issue and releasing commit on one register in one cycle
    focus = "R7";
    idle(); issue(5, 3); step();
    idle(); retire(5, 3, 32'h0000_DDDD); issue(5, 4); look(5, 5); step();
    idle(); look(5, 2); step();

    // R10: gated issues leave mappings unchanged
    focus = "R10";
    idle(); iss_valid = 0; iss_dst_en = 1; iss_dst = 4'd6; iss_tag = 3'd5; look(6, 6); step();
    idle(); iss_valid = 1; iss_dst_en = 0; iss_dst = 4'd6; iss_tag = 3'd5; look(6, 6); step();
    idle(); look(6, 6); step();

    // R9: flush with concurrent rename and commit
    focus = "R9";
    idle(); issue(7, 6); step();
    idle(); issue(8, 7); look(7, 8); step();
    idle(); flush = 1; issue(9, 0); retire(7, 6, 32'h0000_EEEE); look(7, 8); step();
    idle(); look(7, 8); step();
    idle(); look(9, 5); step();

    // mixed traffic
    focus = "mix";
    for (int n = 0; n < 600; n++) begin
      idle();
      if ($urandom_range(0, 3) != 0) issue($urandom_range(0, 15), $urandom_range(0, 7));
      iss_dst_en = iss_valid && ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 2) == 0) begin
        int d = $urandom_range(0, 15);
        retire(d, m_busy[d] && $urandom_range(0, 1) ? m_owner[d] : $urandom_range(0, 7), $urandom);
      end
      flush = ($urandom_range(0, 40) == 0);
      look($urandom_range(0, 15), $urandom_range(0, 15));
      step();
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule